// File: doc/BRIEF.md
# Sequenced Four-Channel Edge-Aligned PWM

The block drives four pulse-width outputs from one shared up-counter, so all channels run at the same frequency while each carries its own duty. The counter advances on a one-cycle tick enable that an external prescaler supplies. It runs from zero up to one less than a programmed top value and then wraps, so every pulse starts at the wrap.

Duty values come from a small sequence buffer of 16-bit words. A start strobe arms the sequencer. At the next wrap it loads the first set of words, one word per channel. Each set can be held for extra periods, and an optional tail of idle periods can follow the last set. A one-cycle done pulse marks the end of playback. The last loaded duties then remain in force until the next start.

Compare updates happen only at a wrap. Compare values of zero or of the top value pin the output to a fixed level for the whole period.

Top module: `pwm_quad_seq`

## Requirements
- R1: The counter takes the values 0 to top_val-1, advances only in cycles where `tick` is high and returns to 0 on the tick after top_val-1, so one period lasts top_val ticks.
- R2: A channel whose loaded word has bit 15 clear is high while the counter is below its compare value and low otherwise, so its high time per period is compare ticks, beginning at the wrap.
- R3: A compare of 0 keeps the output at its idle level for the whole period. A compare equal to or above top_val is clamped to top_val and keeps the output at its active level for the whole period.
- R4: Bit 15 of a duty word set to 1 inverts that channel, so its high time becomes top_val minus the clamped compare.
- R5: Word k of `seq_words` occupies bits [16k+15:16k]. Set s feeds channel c from word s*NUM_CH+c, and the sets play in ascending order.
- R6: Compare values change only at a counter wrap. The first set loads at the first wrap after an accepted start, so the outputs change one clock after that wrap.
- R7: Each set stays in force for 1+hold_reps periods before the next set loads. A hold_reps value of 0 loads a new set every period.
- R8: After the last set's periods, tail_periods further periods elapse. Then `done_o` is high for exactly one cycle, one clock after the closing wrap.
- R9: After done, the last set's duties keep running. A start pulse during playback is ignored and does not move the done pulse.
- R10: After reset all outputs and `done_o` are low, and they stay low until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle count enable from the prescaler |
| top_val | input | 15 | Period length in ticks |
| start | input | 1 | Playback start strobe, accepted while idle |
| seq_words | input | SEQ_SETS*NUM_CH*16 | Duty words: bit 15 invert, bits 14:0 compare |
| hold_reps | input | REP_W | Extra periods each set is held, captured at start |
| tail_periods | input | REP_W | Periods appended after the last set, captured at start |
| pwm_o | output | NUM_CH | Channel outputs |
| done_o | output | 1 | One-cycle end-of-playback pulse |

## Verification
Several rules are checked by assertions on every cycle:
- the counter holds without a tick and returns to zero after a wrap;
- compare registers change only on a load, and a load coincides with a wrap;
- the two compare extremes hold a fixed level;
- done is a single cycle that follows a wrap.

Other behaviour only shows over whole periods, so the bench's scenarios cover it. It measures high time per period for each channel and each set, including the last period of every held set. It also measures the spacing from the first output edge to the done pulse, which reflects the hold and tail counts and the ignored restart. Finally, it checks the duties that persist after playback.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

  localparam int WORD_W = 16;
  localparam int CMP_W  = WORD_W - 1;

  typedef logic [CMP_W-1:0] cmp_t;

  // Layout of one duty word: invert flag on top, compare below it
  typedef struct packed {
    logic invert;
    cmp_t level;
  } duty_word_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ARMED,
    SQ_PLAY,
    SQ_TAIL
  } seq_state_e;

  // Compare value limited to the period length
  function automatic cmp_t clamp_cmp(input cmp_t raw, input cmp_t top);
    return (raw > top) ? top : raw;
  endfunction

  // Output level for a counter position
  function automatic logic drive_level(input cmp_t cnt, input cmp_t cmp, input logic inv);
    return inv ^ (cnt < cmp);
  endfunction

  // True when the next tick must return the counter to zero
  function automatic logic is_last_step(input cmp_t cnt, input cmp_t top);
    logic [CMP_W:0] nxt;
    nxt = {1'b0, cnt} + {{CMP_W{1'b0}}, 1'b1};
    return nxt >= {1'b0, top};
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CMP_W-1:0] top_i,
  output logic [CMP_W-1:0] cnt_o,
  output logic             wrap_o
);

  cmp_t cnt_q;
  logic at_end;

  assign at_end = is_last_step(cnt_q, top_i);
  assign wrap_o = tick_i && at_end;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + cmp_t'(1);
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_o == '0)); // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_o)); // R1

endmodule

// File: rtl/pwm_seq_ctrl.sv
module pwm_seq_ctrl
  import pwm_seq_pkg::*;
#(
  parameter int SEQ_SETS = 2,
  parameter int REP_W    = 8,
  parameter int IDX_W    = (SEQ_SETS > 1) ? $clog2(SEQ_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wrap_i,
  input  logic [REP_W-1:0] hold_i,
  input  logic [REP_W-1:0] tail_i,
  output logic             load_o,
  output logic [IDX_W-1:0] load_idx_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_SETS - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [REP_W-1:0] rep_q;
  logic [REP_W-1:0] tail_q;
  logic [REP_W-1:0] hold_cfg_q;
  logic [REP_W-1:0] tail_cfg_q;

  // Named events for the assertions and the datapath
  logic at_last;
  logic hold_over;
  logic first_load;
  logic step_next;
  logic finish;

  assign at_last    = (idx_q == LAST_IDX);
  assign hold_over  = (rep_q == '0);
  assign first_load = (state_q == SQ_ARMED) && wrap_i;
  assign step_next  = (state_q == SQ_PLAY) && wrap_i && hold_over && !at_last;
  assign finish     = wrap_i &&
                      (((state_q == SQ_PLAY) && hold_over && at_last && (tail_cfg_q == '0)) ||
                       ((state_q == SQ_TAIL) && (tail_q == '0)));

  assign load_o     = first_load || step_next;
  assign load_idx_o = first_load ? '0 : (idx_q + IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      idx_q      <= '0;
      rep_q      <= '0;
      tail_q     <= '0;
      hold_cfg_q <= '0;
      tail_cfg_q <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= finish;
      case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            state_q    <= SQ_ARMED;
            hold_cfg_q <= hold_i;
            tail_cfg_q <= tail_i;
          end
        end
        SQ_ARMED: begin
          if (wrap_i) begin
            state_q <= SQ_PLAY;
            idx_q   <= '0;
            rep_q   <= hold_cfg_q;
          end
        end
        SQ_PLAY: begin
          if (wrap_i) begin
            if (!hold_over) begin
              rep_q <= rep_q - REP_W'(1);
            end else if (!at_last) begin
              idx_q <= idx_q + IDX_W'(1);
              rep_q <= hold_cfg_q;
            end else if (tail_cfg_q != '0) begin
              state_q <= SQ_TAIL;
              tail_q  <= tail_cfg_q - REP_W'(1);
            end else begin
              state_q <= SQ_IDLE;
            end
          end
        end
        SQ_TAIL: begin
          if (wrap_i) begin
            if (tail_q != '0) begin
              tail_q <= tail_q - REP_W'(1);
            end else begin
              state_q <= SQ_IDLE;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_LOAD_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> wrap_i); // R6
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE) |-> !load_o); // R6
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(idx_q) < SEQ_SETS)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wrap_i)); // R8

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CMP_W-1:0]  cnt_i,
  input  logic [CMP_W-1:0]  top_i,
  output logic              pwm_o
);

  duty_word_t w_in;
  cmp_t       cmp_q;
  logic       inv_q;
  logic       lvl_next;

  assign w_in     = duty_word_t'(word_i);
  assign lvl_next = drive_level(cnt_i, cmp_q, inv_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      inv_q <= 1'b0;
      pwm_o <= 1'b0;
    end else begin
      if (load_i) begin
        cmp_q <= clamp_cmp(w_in.level, top_i);
        inv_q <= w_in.invert;
      end
      pwm_o <= lvl_next;
    end
  end

  AST_CMP_STABLE_OFF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(cmp_q) && $stable(inv_q))); // R6
  AST_ZERO_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q == '0) |=> (pwm_o == $past(inv_q))); // R3
  AST_TOP_HOLDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_q >= top_i) && (cnt_i < top_i)) |=> (pwm_o != $past(inv_q))); // R3
  AST_CLAMPED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cmp_q <= $past(top_i))); // R3

endmodule

// File: rtl/pwm_quad_seq.sv
module pwm_quad_seq
  import pwm_seq_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SEQ_SETS = 2,
  parameter int REP_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tick,
  input  logic [CMP_W-1:0]                  top_val,
  input  logic                              start,
  input  logic [SEQ_SETS*NUM_CH*WORD_W-1:0] seq_words,
  input  logic [REP_W-1:0]                  hold_reps,
  input  logic [REP_W-1:0]                  tail_periods,
  output logic [NUM_CH-1:0]                 pwm_o,
  output logic                              done_o
);

  localparam int IDX_W = (SEQ_SETS > 1) ? $clog2(SEQ_SETS) : 1;

  logic [CMP_W-1:0]  cnt;
  logic              wrap;
  logic              load;
  logic [IDX_W-1:0]  load_idx;
  logic [WORD_W-1:0] words [SEQ_SETS][NUM_CH];

  pwm_timebase u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .top_i  (top_val),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  pwm_seq_ctrl #(
    .SEQ_SETS (SEQ_SETS),
    .REP_W    (REP_W),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .wrap_i     (wrap),
    .hold_i     (hold_reps),
    .tail_i     (tail_periods),
    .load_o     (load),
    .load_idx_o (load_idx),
    .done_o     (done_o)
  );

  for (genvar s = 0; s < SEQ_SETS; s++) begin : g_set
    for (genvar c = 0; c < NUM_CH; c++) begin : g_word
      assign words[s][c] = seq_words[(s*NUM_CH + c)*WORD_W +: WORD_W];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_chan u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .word_i (words[load_idx][c]),
      .cnt_i  (cnt),
      .top_i  (top_val),
      .pwm_o  (pwm_o[c])
    );
  end

endmodule

// File: tb/pwm_quad_seq_test.sv
module pwm_quad_seq_test;

  localparam int CLK_NS  = 10;
  localparam int NCH     = 4;
  localparam int NSET    = 2;
  localparam int TRC_MAX = 2048;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick;
  logic [14:0]  top_val = 15'd10;
  logic         start = 1'b0;
  logic [127:0] seq_words = '0;
  logic [7:0]   hold_reps = '0;
  logic [7:0]   tail_periods = '0;
  logic [3:0]   pwm_o;
  logic         done_o;

  int n_chk = 0;
  int n_fail = 0;
  int div_n = 1;
  int div_cnt = 0;

  logic [3:0] trc [TRC_MAX];
  logic       dtr [TRC_MAX];

  always #(CLK_NS/2) clk = ~clk;

  // Prescaled tick, updated away from the active edge
  assign tick = (div_cnt == 0);
  always @(negedge clk) begin
    if (!rst_n || div_cnt >= div_n - 1) div_cnt <= 0;
    else div_cnt <= div_cnt + 1;
  end

  pwm_quad_seq uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .top_val      (top_val),
    .start        (start),
    .seq_words    (seq_words),
    .hold_reps    (hold_reps),
    .tail_periods (tail_periods),
    .pwm_o        (pwm_o),
    .done_o       (done_o)
  );

  task automatic expect_int(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_high(input logic [15:0] w, input int top, input int dv);
    int lvl;
    int h;
    lvl = (int'(w[14:0]) > top) ? top : int'(w[14:0]);
    h = w[15] ? (top - lvl) : lvl;
    return h * dv;
  endfunction

  function automatic logic [15:0] word_of(input logic [127:0] sw, input int s, input int c);
    return sw[(s*NCH + c)*16 +: 16];
  endfunction

  function automatic int count_high(input int from, input int len, input int c);
    int n = 0;
    for (int i = from; i < from + len; i++) if (trc[i][c]) n++;
    return n;
  endfunction

  task automatic run_case(input string name, input int top, input int dv, input int rep,
                          input int tail, input logic [127:0] sw, input bit restart);
    int per;
    int nper;
    int total;
    int seen;
    int d_idx;
    int d_cnt;
    int rise;
    per  = top * dv;
    nper = NSET * (1 + rep) + tail;
    total = nper * per + per + 2;
    rst_n = 1'b0;
    top_val = 15'(top);
    div_n = dv;
    hold_reps = 8'(rep);
    tail_periods = 8'(tail);
    seq_words = sw;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_int("R10", {name, " pwm after reset"}, int'(pwm_o), 0);
    expect_int("R10", {name, " done after reset"}, int'(done_o), 0);
    // No start: nothing may load, outputs stay idle for two periods
    seen = 0;
    for (int i = 0; i < 2*per; i++) begin
      @(negedge clk);
      if (pwm_o != 4'd0 || done_o) seen++;
    end
    expect_int("R10", {name, " activity before start"}, seen, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int i = 0; i < 3*per + 10; i++) begin
      if (pwm_o[0]) begin
        seen = 1;
        break;
      end
      @(negedge clk);
    end
    expect_int("R6", {name, " first set reaches ch0"}, seen, 1);
    if (seen == 0) return;
    for (int i = 0; i < total; i++) begin
      trc[i] = pwm_o;
      dtr[i] = done_o;
      if (restart) start = (i == per + 1);
      @(negedge clk);
    end
    start = 1'b0;
    d_idx = -1;
    d_cnt = 0;
    for (int i = 0; i < total; i++) begin
      if (dtr[i]) begin
        d_cnt++;
        if (d_idx < 0) d_idx = i;
      end
    end
    expect_int(restart ? "R9" : "R8", {name, " done offset"}, d_idx, nper*per - 1);
    expect_int("R8", {name, " done pulse count"}, d_cnt, 1);
    if (rep >= 1) begin
      rise = -1;
      for (int i = 1; i < 2*per; i++) begin
        if (trc[i][0] && !trc[i-1][0]) begin
          rise = i;
          break;
        end
      end
      expect_int("R1", {name, " period of ch0"}, rise, per);
    end
    for (int s = 0; s < NSET; s++) begin
      for (int c = 0; c < NCH; c++) begin
        // R2 R3 R4 R5: high time of set s, channel c, first period
        expect_int("R2/R3/R4/R5", $sformatf("%s set%0d ch%0d high", name, s, c),
                   count_high(s*(1+rep)*per, per, c), exp_high(word_of(sw, s, c), top, dv));
        if (rep >= 1)
          expect_int("R7", $sformatf("%s set%0d ch%0d held", name, s, c),
                     count_high((s*(1+rep)+rep)*per, per, c), exp_high(word_of(sw, s, c), top, dv));
      end
    end
    if (d_idx >= 0 && d_idx + 1 + per <= total) begin
      for (int c = 0; c < NCH; c++)
        expect_int("R9", $sformatf("%s ch%0d after done", name, c),
                   count_high(d_idx + 1, per, c), exp_high(word_of(sw, NSET-1, c), top, dv));
    end
  endtask

  function automatic logic [15:0] rand_word(input int top);
    logic [14:0] lvl;
    case ($urandom_range(0, 3))
      0: lvl = 15'd0;
      1: lvl = 15'(top);
      2: lvl = 15'(top + $urandom_range(1, 20));
      default: lvl = 15'($urandom_range(0, top));
    endcase
    return {1'($urandom_range(0, 1)), lvl};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [127:0] sw;
    int seed;
    int top;
    seed = $urandom(32'd20240611);
    // Directed: extremes, clamp, inversion, new set every period
    sw = '0;
    sw[0*16 +: 16] = {1'b0, 15'd4};
    sw[1*16 +: 16] = {1'b0, 15'd0};
    sw[2*16 +: 16] = {1'b0, 15'd10};
    sw[3*16 +: 16] = {1'b1, 15'd3};
    sw[4*16 +: 16] = {1'b0, 15'd7};
    sw[5*16 +: 16] = {1'b0, 15'd20};
    sw[6*16 +: 16] = {1'b1, 15'd0};
    sw[7*16 +: 16] = {1'b1, 15'd10};
    run_case("dirA", 10, 1, 0, 0, sw, 1'b0);
    // Directed: prescaled tick, holds, tail, ignored restart
    sw[0*16 +: 16] = {1'b0, 15'd3};
    sw[1*16 +: 16] = {1'b1, 15'd8};
    sw[2*16 +: 16] = {1'b0, 15'd1};
    sw[3*16 +: 16] = {1'b1, 15'd5};
    sw[4*16 +: 16] = {1'b0, 15'd8};
    sw[5*16 +: 16] = {1'b1, 15'd2};
    sw[6*16 +: 16] = {1'b0, 15'd30};
    sw[7*16 +: 16] = {1'b0, 15'd6};
    run_case("dirB", 8, 3, 2, 3, sw, 1'b1);
    for (int k = 0; k < 5; k++) begin
      top = $urandom_range(2, 40);
      for (int w = 0; w < NSET*NCH; w++) sw[w*16 +: 16] = rand_word(top);
      sw[15:0] = {1'b0, 15'($urandom_range(1, top - 1))};
      run_case($sformatf("rnd%0d", k), top, $urandom_range(1, 3), $urandom_range(0, 3),
               $urandom_range(0, 3), sw, k[0]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule